// File: doc/BRIEF.md
# Popcount Bulk Bitwise Logic Unit

This block performs a bitwise logic operation across a stack of up to seven operand words at once. Every bit column is reduced to one figure: how many of the participating operands hold a one in that column. The Boolean result for that column is then read off that figure for the chosen function. The logic never knows which operands hold the ones. The same counter therefore serves AND, OR, XOR, majority and their inverses, for any number of operands from two to seven.

A request carries all seven operand words side by side on one flat bus, a mask that marks the participating operands, and a function code. The participating operands must form one unbroken run of adjacent rows. A request is accepted on a valid/ready handshake, and the whole word is evaluated in a single cycle. The result is registered and is offered on the following cycle. It is held while the consumer stalls. Requests that name fewer than two operands, or a broken run, raise an error flag and return operand 0 unchanged.

Top module: `popcount_logic_unit`

## Requirements
- R1: After reset, out_valid, out_err and every bit of out_word are 0.
- R2: in_ready equals (not out_valid) or out_ready. A request accepted on a clock edge (in_valid and in_ready high) makes out_valid 1 after that edge. While out_valid is 1 and out_ready is 0, out_valid, out_word and out_err hold their values.
- R3: Function code 0 (AND) gives a 1 in a column exactly when the ones-count of that column equals the number of active operands.
- R4: Function code 1 (OR) gives a 1 in a column exactly when the ones-count of that column is nonzero.
- R5: Function code 2 (XOR) gives a 1 in a column exactly when the ones-count of that column is odd.
- R6: Function code 3 (majority) gives a 1 exactly when twice the ones-count is greater than the number of active operands. A tie with an even operand count gives 0.
- R7: Bit 2 of the function code inverts the result of the function selected by bits 1:0. Code 4 is NAND, 5 is NOR, 6 is XNOR and 7 is inverted majority.
- R8: Operand k is active when bit k of in_mask is 1. Operand k occupies bits k*WIDTH+WIDTH-1 down to k*WIDTH of in_opnds. Inactive operands have no effect on the result.
- R9: When in_mask has fewer than two bits set, or its set bits are not one contiguous run, out_err is 1 and out_word equals operand 0 of that request, whatever the function code. Otherwise out_err is 0.
- R10: With out_ready held at 1, a new request can be accepted on every cycle. out_valid falls after a transfer when no new request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_opnds | input | NOPS*WIDTH | Operand words, operand k at slice k |
| in_mask | input | NOPS | Active operand mask, one contiguous run |
| in_func | input | 3 | Function code |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | WIDTH | Result word |
| out_err | output | 1 | Too few operands or broken run; out_word is operand 0 |

## Verification
Two things can fall in the same cycle: the handoff of the held result to the consumer, and the capture of a new request into that same output register. The bench provokes this with back-to-back requests under out_ready held high. It also runs long stretches in which in_valid and out_ready toggle at random, so that a stall, a drain and a replace follow one another in every order. On every cycle a behavioural model built on integer counts predicts in_ready, out_valid, out_word and out_err. Any difference, for example a result lost or duplicated at a drain-and-refill edge, is reported against the requirement being exercised.

// File: rtl/popcount_logic_unit.sv
module popcount_logic_unit #(
  parameter int WIDTH = 512,
  parameter int NOPS  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NOPS*WIDTH-1:0] in_opnds,
  input  logic [NOPS-1:0]       in_mask,
  input  logic [2:0]            in_func,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WIDTH-1:0]      out_word,
  output logic                  out_err
);
  localparam int CW = $clog2(NOPS + 1);

  logic [CW-1:0]    n_act;
  logic [NOPS-1:0]  low_bit;
  logic [NOPS:0]    run_sum;
  logic             bad_req;
  logic             accept;
  logic [WIDTH-1:0] eval_word;

  always_comb begin
    n_act = '0;
    for (int k = 0; k < NOPS; k++)
      n_act = n_act + CW'(in_mask[k]);
  end

  assign low_bit = in_mask & (~in_mask + NOPS'(1));
  assign run_sum = {1'b0, in_mask} + {1'b0, low_bit};
  assign bad_req = (n_act < CW'(2)) || ((run_sum & {1'b0, in_mask}) != '0);

  generate
    for (genvar c = 0; c < WIDTH; c++) begin : g_col
      logic [CW-1:0] ones;
      logic          base;
      always_comb begin
        ones = '0;
        for (int k = 0; k < NOPS; k++)
          ones = ones + CW'(in_opnds[k*WIDTH+c] & in_mask[k]);
        case (in_func[1:0])
          2'd0:    base = (ones == n_act);
          2'd1:    base = (ones != '0);
          2'd2:    base = ones[0];
          default: base = ({ones, 1'b0} > {1'b0, n_act});
        endcase
      end
      assign eval_word[c] = base ^ in_func[2];
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_word  <= bad_req ? in_opnds[WIDTH-1:0] : eval_word;
      out_err   <= bad_req;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/popcount_logic_unit_chk.sv
module popcount_logic_unit_chk #(
  parameter int WIDTH = 512,
  parameter int NOPS  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [NOPS*WIDTH-1:0] in_opnds,
  input logic [NOPS-1:0]       in_mask,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WIDTH-1:0]      out_word,
  input logic                  out_err
);
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_err));

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ($countones(in_mask) < 2)
      |=> out_err && (out_word == $past(in_opnds[WIDTH-1:0])));
endmodule

bind popcount_logic_unit popcount_logic_unit_chk #(.WIDTH(WIDTH), .NOPS(NOPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opnds(in_opnds), .in_mask(in_mask), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_err(out_err)
);

// File: tb/tb_popcount_logic_unit.sv
`timescale 1ns/1ps
module tb_popcount_logic_unit;
  localparam int W = 512;
  localparam int N = 7;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [N*W-1:0] in_opnds = '0;
  logic [N-1:0] in_mask = '0;
  logic [2:0] in_func = '0;
  logic in_ready, out_valid, out_err;
  logic [W-1:0] out_word;

  popcount_logic_unit #(.WIDTH(W), .NOPS(N)) dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit m_valid = 0, m_err = 0, done = 0;
  logic [W-1:0] m_word = '0;

  function automatic bit ref_bad(logic [N-1:0] m);
    int n = 0, starts = 0;
    for (int k = 0; k < N; k++) begin
      if (m[k]) n++;
      if (m[k] && (k == 0 || !m[k-1])) starts++;
    end
    return (n < 2) || (starts != 1);
  endfunction

  function automatic logic [W-1:0] ref_word(logic [N*W-1:0] ops, logic [N-1:0] m, logic [2:0] f);
    logic [W-1:0] r;
    int n = 0;
    for (int k = 0; k < N; k++) if (m[k]) n++;
    if (ref_bad(m)) return ops[W-1:0];
    for (int c = 0; c < W; c++) begin
      int ones = 0;
      bit b;
      for (int k = 0; k < N; k++) if (m[k] && ops[k*W+c]) ones++;
      case (f[1:0])
        0: b = (ones == n);
        1: b = (ones > 0);
        2: b = (ones % 2 == 1);
        default: b = (2*ones > n);
      endcase
      r[c] = f[2] ? !b : b;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_err = 0; m_word = '0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid = 1;
      m_err = ref_bad(in_mask);
      m_word = ref_word(in_opnds, in_mask, in_func);
    end else if (out_ready) m_valid = 0;
  end

  task automatic check_bit(string tag, string what, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check_bit(tag, "out_valid", out_valid, m_valid);
    if (m_valid) begin
      check_bit(tag, "out_err", out_err, m_err);
      total++;
      if (out_word !== m_word) begin
        bad++;
        $display("FAIL %s out_word actual=%h expected=%h", tag, out_word, m_word);
      end
    end
  endtask

  function automatic logic [N*W-1:0] rand_ops();
    logic [N*W-1:0] v;
    for (int i = 0; i < N*W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic step(string tag, bit iv, bit ordy, logic [N*W-1:0] ops,
                      logic [N-1:0] m, logic [2:0] f);
    @(negedge clk);
    compare(tag);
    in_valid = iv; out_ready = ordy; in_opnds = ops; in_mask = m; in_func = f;
    #1;
    check_bit("R2", "in_ready", in_ready, !m_valid || ordy);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog run did not end");
    finish_run();
  end

  initial begin
    logic [N*W-1:0] ones_all;
    ones_all = '1;
    repeat (3) @(negedge clk);
    check_bit("R1", "out_valid", out_valid, 0);
    check_bit("R1", "out_err", out_err, 0);
    total++;
    if (out_word !== '0) begin bad++; $display("FAIL R1 out_word actual=%h expected=0", out_word); end
    @(negedge clk); rst_n = 1;

    step("R3", 1, 1, ones_all, 7'h7f, 3'd0);
    step("R3", 1, 1, rand_ops(), 7'h7f, 3'd0);
    step("R4", 1, 1, rand_ops(), 7'h7f, 3'd1);
    step("R4", 1, 1, '0, 7'h3e, 3'd1);
    step("R5", 1, 1, rand_ops(), 7'h7f, 3'd2);
    step("R5", 1, 1, rand_ops(), 7'h06, 3'd2);
    step("R6", 1, 1, rand_ops(), 7'h7f, 3'd3);
    step("R6", 1, 1, rand_ops(), 7'h0f, 3'd3);
    step("R6", 1, 1, {5'd0, 1'b1, 1'b1, 2'b0, 1'b1} == '0 ? '0 : ones_all >> (4*W), 7'h0f, 3'd3);
    for (int f = 4; f < 8; f++) step("R7", 1, 1, rand_ops(), 7'h7f, 3'(f));
    step("R7", 1, 1, rand_ops(), 7'h1c, 3'd6);
    step("R8", 1, 1, rand_ops(), 7'h1c, 3'd0);
    step("R8", 1, 1, ones_all, 7'h60, 3'd4);
    step("R8", 1, 1, {ones_all[N*W-1:3*W], {(3*W){1'b0}}}, 7'h07, 3'd1);
    step("R9", 1, 1, rand_ops(), 7'h00, 3'd1);
    step("R9", 1, 1, rand_ops(), 7'h08, 3'd2);
    step("R9", 1, 1, rand_ops(), 7'h51, 3'd0);
    step("R9", 1, 1, rand_ops(), 7'h0b, 3'd7);
    step("R10", 0, 1, '0, '0, '0);
    step("R10", 0, 1, '0, '0, '0);
    step("R2", 1, 0, rand_ops(), 7'h3f, 3'd2);
    step("R2", 1, 0, rand_ops(), 7'h3f, 3'd1);
    step("R2", 1, 0, rand_ops(), 7'h03, 3'd5);
    step("R2", 1, 1, rand_ops(), 7'h7c, 3'd3);
    for (int i = 0; i < 6; i++) step("R10", 1, 1, rand_ops(), 7'h7f, 3'(i));
    step("R10", 0, 1, '0, '0, '0);
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] m;
      int lo, len;
      lo = $urandom_range(0, N-1);
      len = $urandom_range(0, N - lo);
      m = '0;
      for (int k = lo; k < lo + len; k++) m[k] = 1'b1;
      if ($urandom_range(0, 9) == 0) m = N'($urandom);
      step("R2", $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, rand_ops(), m, 3'($urandom));
    end
    step("R10", 0, 1, '0, '0, '0);
    step("R10", 0, 1, '0, '0, '0);
    @(negedge clk);
    compare("R10");
    finish_run();
  end
endmodule